// File: doc/BRIEF.md
# Keyed-Write Watchdog Timer

This block is an 8-bit watchdog counter with a control/status byte, both reachable from a simple bus slave port. The two registers share one write address. A write reaches them only as a full 16-bit transfer, and the upper byte of that transfer acts as a key. One key value steers the lower byte into the counter and the other steers it into the control/status byte. Any other key, any byte-size transfer, and any write to another address leave both registers untouched. Reads are plain byte reads from two neighbouring addresses.

When enabled, the counter advances on each prescaler tick supplied from outside. When it wraps from 0xFF to 0x00, one of two things happens. The overflow flag is set and drives the interrupt output, or, if reset-on-overflow is enabled, a one-cycle internal reset request is issued and the block reinitialises itself. A read-only reset-source flag tells software which kind of reset happened last. The external reset pin sets it to 1, and an overflow-triggered internal reset clears it to 0.

Top module: `wdt_keyed`

## Requirements
- R1: A write with `word` low, whatever its address, data or upper byte, changes neither the counter nor the control/status byte.
- R2: A word write to address 0xFFA8 whose upper byte is 0x5A loads the lower byte into the counter. The new value is readable after the next clock edge.
- R3: A word write to address 0xFFA8 whose upper byte is 0xA5 loads bit 6 (reset-on-overflow enable) and bit 5 (timer enable) from the lower byte. Bit 7 of the lower byte can only clear the overflow flag, never set it.
- R4: A word write to 0xFFA8 with any upper byte other than 0x5A or 0xA5 changes neither register. So does a word write to any other address.
- R5: When `rd` is high, `rdata` returns the control/status byte for address 0xFFA8 and the counter for address 0xFFA9, in the same cycle. The status byte is laid out as {overflow, reset enable, timer enable, 0, reset source, 0, 0, 0}. Any other address, or `rd` low, returns 0x00.
- R6: Bit 3 (reset source) cannot be changed by any write. The external reset sets it to 1.
- R7: The counter increments by one on each clock edge where `tick` is high and timer enable is 1. It holds while timer enable is 0.
- R8: With reset enable at 0, a tick taking the counter from 0xFF to 0x00 sets the overflow flag and raises `irq` from the following cycle on. `rst_req` stays low.
- R9: With reset enable at 1, a tick at counter 0xFF raises `rst_req` for exactly one cycle after that edge. In that same cycle the counter, overflow, reset-enable and timer-enable bits are 0, the reset source reads 0 and `irq` is low.
- R10: While and after the external reset is applied, the counter reads 0x00, the status byte reads 0x08, and both `irq` and `rst_req` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | External reset, active low |
| addr | input | 16 | Bus address |
| wdata | input | 16 | Write data; upper byte is the key |
| word | input | 1 | 1 = word transfer, 0 = byte transfer |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| tick | input | 1 | Prescaler tick, one cycle wide |
| rdata | output | 8 | Read data |
| irq | output | 1 | Overflow interrupt (level) |
| rst_req | output | 1 | Internal reset request pulse |

## Verification
Register writes and counter ticks are captured on one clock edge, so their effects are due at the first falling edge after that edge. The bench drives each stimulus at a falling edge, releases it at the next, and compares at that same falling edge. Read data is combinational, so reads are compared a fraction of a cycle after `rd` and `addr` settle, with no edge in between. The overflow interrupt and the reset-request pulse both appear one edge after the wrapping tick. The pulse is also checked to be gone one further cycle later.

// File: rtl/wdt_keyed.sv
module wdt_keyed #(
  parameter logic [15:0] ADDR_CSR = 16'hFFA8,
  parameter logic [15:0] ADDR_CNT = 16'hFFA9,
  parameter logic [7:0]  KEY_CNT  = 8'h5A,
  parameter logic [7:0]  KEY_CSR  = 8'hA5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] addr,
  input  logic [15:0] wdata,
  input  logic        word,
  input  logic        wr,
  input  logic        rd,
  input  logic        tick,
  output logic [7:0]  rdata,
  output logic        irq,
  output logic        rst_req
);

  logic [7:0] cnt;
  logic       ovf, ren, ten, rsrc, req;
  logic [7:0] csr;

  wire hit    = wr && word && (addr == ADDR_CSR);
  wire ld_cnt = hit && (wdata[15:8] == KEY_CNT);
  wire ld_csr = hit && (wdata[15:8] == KEY_CSR);
  wire step   = tick && ten && !ld_cnt;
  wire wrap   = step && (cnt == 8'hFF);
  wire kill   = wrap && ren;

  assign csr     = {ovf, ren, ten, 1'b0, rsrc, 3'b000};
  assign irq     = ovf;
  assign rst_req = req;
  assign rdata   = !rd ? 8'h00 :
                   (addr == ADDR_CSR) ? csr :
                   (addr == ADDR_CNT) ? cnt : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= 8'h00;
      ovf  <= 1'b0;
      ren  <= 1'b0;
      ten  <= 1'b0;
      rsrc <= 1'b1;
      req  <= 1'b0;
    end else begin
      req <= kill;
      if (kill) begin
        cnt  <= 8'h00;
        ovf  <= 1'b0;
        ren  <= 1'b0;
        ten  <= 1'b0;
        rsrc <= 1'b0;
      end else begin
        if (ld_cnt)    cnt <= wdata[7:0];
        else if (step) cnt <= cnt + 8'h01;
        if (ld_csr) begin
          ren <= wdata[6];
          ten <= wdata[5];
        end
        if (wrap)        ovf <= 1'b1;
        else if (ld_csr) ovf <= ovf & wdata[7];
      end
    end
  end

  assert_byte_write_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !word && !tick) |=> ($stable(cnt) && $stable(csr)));

  assert_cnt_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && word && addr == ADDR_CSR && wdata[15:8] == KEY_CNT) |=> (cnt == $past(wdata[7:0])));

  assert_bad_key_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && word && !tick && wdata[15:8] != KEY_CNT && wdata[15:8] != KEY_CSR)
      |=> ($stable(cnt) && $stable(csr)));

  assert_rsrc_readonly_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsrc != $past(rsrc)) |-> (rst_req && !rsrc));

  assert_no_req_when_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> ($past(ren) && $past(cnt) == 8'hFF));

  assert_req_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

endmodule

// File: tb/tb_wdt_keyed.sv
module tb_wdt_keyed;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic [15:0] wdata = 16'h0000;
  logic        word = 1'b0, wr = 1'b0, rd = 1'b0, tick = 1'b0;
  logic [7:0]  rdata;
  logic        irq, rst_req;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] m_cnt;
  logic m_ovf, m_ren, m_ten, m_rsrc;

  always #4 clk = ~clk;

  wdt_keyed dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .word(word),
                 .wr(wr), .rd(rd), .tick(tick), .rdata(rdata), .irq(irq), .rst_req(rst_req));

  function automatic logic [7:0] m_csr();
    return {m_ovf, m_ren, m_ten, 1'b0, m_rsrc, 3'b000};
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic rd_chk(input string req, input logic [15:0] a, input logic [7:0] exp);
    addr = a; rd = 1'b1; #1;
    check(req, rdata, exp);
    rd = 1'b0; #1;
  endtask

  task automatic regs_chk(input string req);
    rd_chk(req, 16'hFFA9, m_cnt);
    rd_chk(req, 16'hFFA8, m_csr());
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [15:0] d, input logic w);
    @(negedge clk);
    addr = a; wdata = d; word = w; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic do_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic ext_reset();
    @(negedge clk);
    rst_n = 1'b0;
    m_cnt = 8'h00; m_ovf = 1'b0; m_ren = 1'b0; m_ten = 1'b0; m_rsrc = 1'b1;
    @(negedge clk);
    regs_chk("R10");
    check("R10", {6'b0, irq, rst_req}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    regs_chk("R10");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R1 got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    ext_reset();
    check("R6", m_csr(), 8'h08);

    rd = 1'b0; addr = 16'hFFA9; #1;
    check("R5", rdata, 8'h00);
    for (int a = 16'hFFA0; a <= 16'hFFAF; a++)
      if (a != 16'hFFA8 && a != 16'hFFA9) rd_chk("R5", a[15:0], 8'h00);

    for (int v = 0; v < 256; v++) begin
      bus_wr(16'hFFA8, {8'h5A, v[7:0]}, 1'b1);
      m_cnt = v[7:0];
      rd_chk("R2", 16'hFFA9, m_cnt);
    end

    for (int k = 0; k < 256; k++) begin
      logic [7:0] lo;
      lo = (k[7:0] ^ 8'h3C) & 8'hBF;
      bus_wr(16'hFFA8, {k[7:0], lo}, 1'b1);
      if (k == 8'h5A) m_cnt = lo;
      else if (k == 8'hA5) begin
        m_ovf = m_ovf & lo[7]; m_ren = lo[6]; m_ten = lo[5];
      end
      regs_chk((k == 8'h5A) ? "R2" : (k == 8'hA5) ? "R3" : "R4");
    end

    bus_wr(16'hFFA8, 16'hA500, 1'b1);
    m_ten = 1'b0; m_ren = 1'b0;
    bus_wr(16'hFFA8, 16'h5A11, 1'b1);
    m_cnt = 8'h11;
    for (int v = 0; v < 256; v++) begin
      bus_wr(16'hFFA8, {8'h5A, v[7:0]}, 1'b0);
      bus_wr(16'hFFA8, {8'hA5, v[7:0]}, 1'b0);
      regs_chk("R1");
    end
    bus_wr(16'hFFA9, 16'h5A77, 1'b1);
    bus_wr(16'hFFAA, 16'hA520, 1'b1);
    bus_wr(16'h0000, 16'h5A77, 1'b1);
    regs_chk("R4");

    bus_wr(16'hFFA8, 16'hA5FF, 1'b1);
    m_ren = 1'b1; m_ten = 1'b1;
    check("R6", m_csr(), 8'h68);
    regs_chk("R6");
    bus_wr(16'hFFA8, 16'hA500, 1'b1);
    m_ren = 1'b0; m_ten = 1'b0;
    rd_chk("R6", 16'hFFA8, 8'h08);

    for (int i = 0; i < 5; i++) do_tick();
    regs_chk("R7");

    bus_wr(16'hFFA8, 16'hA520, 1'b1);
    m_ten = 1'b1;
    for (int i = 0; i < 40; i++) begin
      do_tick();
      m_cnt = m_cnt + 8'h01;
      rd_chk("R7", 16'hFFA9, m_cnt);
    end

    bus_wr(16'hFFA8, 16'h5AFE, 1'b1);
    m_cnt = 8'hFE;
    do_tick();
    m_cnt = 8'hFF;
    check("R8", {7'b0, irq}, 8'h00);
    do_tick();
    m_cnt = 8'h00; m_ovf = 1'b1;
    check("R8", {7'b0, irq}, 8'h01);
    check("R8", {7'b0, rst_req}, 8'h00);
    regs_chk("R8");
    @(negedge clk);
    check("R8", {7'b0, rst_req}, 8'h00);
    bus_wr(16'hFFA8, 16'hA5A0, 1'b1);
    regs_chk("R3");
    bus_wr(16'hFFA8, 16'hA520, 1'b1);
    m_ovf = 1'b0;
    regs_chk("R3");
    check("R3", {7'b0, irq}, 8'h00);

    bus_wr(16'hFFA8, 16'h5AFF, 1'b1);
    bus_wr(16'hFFA8, 16'hA560, 1'b1);
    m_cnt = 8'hFF; m_ren = 1'b1; m_ten = 1'b1;
    regs_chk("R9");
    do_tick();
    m_cnt = 8'h00; m_ovf = 1'b0; m_ren = 1'b0; m_ten = 1'b0; m_rsrc = 1'b0;
    check("R9", {7'b0, rst_req}, 8'h01);
    check("R9", {7'b0, irq}, 8'h00);
    regs_chk("R9");
    @(negedge clk);
    check("R9", {7'b0, rst_req}, 8'h00);
    rd_chk("R9", 16'hFFA8, 8'h00);
    bus_wr(16'hFFA8, 16'hA508, 1'b1);
    rd_chk("R6", 16'hFFA8, 8'h00);

    ext_reset();
    rd_chk("R6", 16'hFFA8, 8'h08);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule